// File: doc/BRIEF.md
# Clocked Host Bus Burst Slave

This block is the slave end of a clocked parallel host bus. Through it the host reaches two targets: a 32-bit shared memory and a register file. A transfer opens when the select and strobe inputs are both low at a rising edge. The block then paces the host with an active-low ready output.

Transfers carry one word or a sequential burst. A burst samples its start address once and then steps through consecutive addresses. The host marks the final word by pulling its last-word input low.

Memory writes take effect at once. Register writes go into a posted command queue, which empties into the register file at half the clock rate. When the queue is full, a stop output tells the host to hold its word. A register read waits until the queue is empty, so it always returns the drained value. A two-bit half-word enable masks writes and zeroes the unused halves of read data.

Top module: `hbus_burst_slave`

## Requirements
- R1: While reset is applied and in the first cycle after it, `rdy_n` and `stop_n` are high, `rdata_oe` is low and `rdata` is zero.
- R2: A transfer starts at a rising edge where `sel_n` and `strb_n` are both low; `addr`, `rnw`, `reg_sel` and `hen` are sampled only then, and word k of the burst uses address start+k modulo the address space.
- R3: For a write, `rdy_n` goes low in the cycle right after the start edge; the first data word is taken at the end of the following cycle, and one word is taken per cycle after that.
- R4: At the first rising edge in a data cycle where `last_n` is sampled low, the transfer ends: in the next cycle `rdy_n` is high and `rdata_oe` is low.
- R5: A memory read drives its first word, with `rdy_n` low and `rdata_oe` high, in the second cycle after the start edge; a single-word read (with `last_n` held low) holds `rdy_n` low for exactly one cycle.
- R6: After a transfer ends, `sel_n` must be sampled high at one edge or more before a new start; a strobe while select stays low is ignored.
- R7: A register write is posted into a command queue of `FIFO_DEPTH` entries, and the queue retires at most one entry every second clock.
- R8: During the data cycles of a write, `stop_n` is low only while the queue is full. The word presented in that cycle is not taken and the address does not advance. Memory writes never see `stop_n` low.
- R9: A register read produces no data until the command queue is empty, and it returns the value left by the last posted write to that register.
- R10: In each data cycle of a register read, `stop_n` is low together with `rdy_n`.
- R11: `hen[0]` covers bits 15:0 and `hen[1]` covers bits 31:16. A memory write leaves a half unchanged when its enable bit is 0. A read returns zero in that half.
- R12: A register access with `hen` other than 2'b11 still completes the handshake, but a write is discarded and a read returns zero.
- R13: Outside read data cycles, `rdata` is zero and `rdata_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Slave select, active low |
| strb_n | input | 1 | Start strobe, active low, one cycle |
| rnw | input | 1 | 1 = read, 0 = write |
| reg_sel | input | 1 | 1 = register file, 0 = memory |
| last_n | input | 1 | Final word of burst, active low |
| hen | input | 2 | Half-word enables (bit 1 upper, bit 0 lower) |
| addr | input | ADDR_W | Start word address |
| wdata | input | 32 | Write data |
| rdy_n | output | 1 | Data ready, active low |
| stop_n | output | 1 | Back-off / register read marker, active low |
| rdata_oe | output | 1 | Read data driven (bus enable) |
| rdata | output | 32 | Read data, zero when not driven |

## Verification
The main handshake is exercised with a table of transfers. It covers memory bursts that wrap the address space, single words, and partial half-word enables on both writes and reads. Together these separate a sequential address counter from a stuck one, and a masked write from a full one. Register bursts of different lengths tell posted writes apart from immediate ones. The longest burst drives the queue full, which exposes whether stop appears only on a full queue. A short read right after a burst shows whether draining runs at half rate or full rate. Directed cases cover the strobe ignored while select stays low and register accesses with partial enables.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

    localparam int DATA_W = 32;
    localparam int HALF_W = 16;

    typedef logic [1:0] hen_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WPRE,
        S_WDAT,
        S_RWAIT,
        S_RDAT,
        S_END
    } phase_e;

    typedef struct packed {
        logic is_reg;
        hen_t hen;
    } attr_t;

    // keep old halves whose enable is clear
    function automatic logic [DATA_W-1:0] half_merge(input logic [DATA_W-1:0] old_w,
                                                     input logic [DATA_W-1:0] new_w,
                                                     input hen_t hen);
        logic [DATA_W-1:0] r;
        for (int h = 0; h < 2; h++)
            r[h*HALF_W +: HALF_W] = hen[h] ? new_w[h*HALF_W +: HALF_W] : old_w[h*HALF_W +: HALF_W];
        return r;
    endfunction

    // zero halves whose enable is clear
    function automatic logic [DATA_W-1:0] half_zero(input logic [DATA_W-1:0] w, input hen_t hen);
        logic [DATA_W-1:0] r;
        for (int h = 0; h < 2; h++)
            r[h*HALF_W +: HALF_W] = hen[h] ? w[h*HALF_W +: HALF_W] : '0;
        return r;
    endfunction

endpackage

// File: rtl/hbs_cmd_fifo.sv
module hbs_cmd_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 36
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_P = PTR_W'(DEPTH - 1);

    logic [W-1:0]     slots [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [CNT_W-1:0] cnt;
    logic             tick;
    logic             push_ok;

    assign full    = (cnt == CNT_W'(DEPTH));
    assign empty   = (cnt == '0);
    assign push_ok = push && !full;
    assign pop     = tick && !empty;
    assign head    = slots[rp];

    always_ff @(posedge clk) begin
        if (push_ok) slots[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp   <= '0;
            rp   <= '0;
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= ~tick;
            if (push_ok) wp <= (wp == LAST_P) ? '0 : wp + 1'b1;
            if (pop)     rp <= (rp == LAST_P) ? '0 : rp + 1'b1;
            case ({push_ok, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/hbs_ctrl.sv
module hbs_ctrl
    import hbs_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              strb_n,
    input  logic              rnw,
    input  logic              reg_sel,
    input  logic              last_n,
    input  hen_t              hen,
    input  logic [ADDR_W-1:0] addr,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    output logic [ADDR_W-1:0] cur_addr,
    output attr_t             cur_attr,
    output logic              wr_fire,
    output logic              rd_act,
    output logic              rdy_n,
    output logic              stop_n
);
    phase_e phase;
    logic   accept;

    assign accept  = !cur_attr.is_reg || !fifo_full;
    assign wr_fire = (phase == S_WDAT) && accept;
    assign rd_act  = (phase == S_RDAT);
    assign rdy_n   = !((phase == S_WPRE) || (phase == S_WDAT) || (phase == S_RDAT));
    assign stop_n  = !(((phase == S_WDAT) && cur_attr.is_reg && fifo_full) ||
                       ((phase == S_RDAT) && cur_attr.is_reg));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= S_IDLE;
            cur_addr <= '0;
            cur_attr <= '0;
        end else begin
            case (phase)
                S_IDLE: if (!sel_n && !strb_n) begin
                    cur_addr <= addr;
                    cur_attr <= '{is_reg: reg_sel, hen: hen};
                    phase    <= rnw ? S_RWAIT : S_WPRE;
                end
                S_WPRE: phase <= S_WDAT;
                S_WDAT: if (accept) begin
                    cur_addr <= cur_addr + 1'b1;
                    if (!last_n) phase <= S_END;
                end
                S_RWAIT: if (!cur_attr.is_reg || fifo_empty) phase <= S_RDAT;
                S_RDAT: begin
                    if (!last_n) phase <= S_END;
                    else         cur_addr <= cur_addr + 1'b1;
                end
                S_END: if (sel_n) phase <= S_IDLE;
                default: phase <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hbus_burst_slave.sv
module hbus_burst_slave
    import hbs_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              strb_n,
    input  logic              rnw,
    input  logic              reg_sel,
    input  logic              last_n,
    input  logic [1:0]        hen,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic              rdy_n,
    output logic              stop_n,
    output logic              rdata_oe,
    output logic [31:0]       rdata
);
    localparam int WORDS   = 1 << ADDR_W;
    localparam int ENTRY_W = ADDR_W + DATA_W;

    logic [DATA_W-1:0]  mem  [WORDS];
    logic [DATA_W-1:0]  regs [WORDS];
    logic [ADDR_W-1:0]  cur_addr;
    attr_t              cur_attr;
    logic               wr_fire, rd_act, push, pop, fifo_full, fifo_empty;
    logic [ENTRY_W-1:0] head;
    logic [DATA_W-1:0]  raw;

    hbs_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk(clk), .rst(rst), .sel_n(sel_n), .strb_n(strb_n), .rnw(rnw),
        .reg_sel(reg_sel), .last_n(last_n), .hen(hen), .addr(addr),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .cur_addr(cur_addr), .cur_attr(cur_attr), .wr_fire(wr_fire),
        .rd_act(rd_act), .rdy_n(rdy_n), .stop_n(stop_n)
    );

    assign push = wr_fire && cur_attr.is_reg && (cur_attr.hen == 2'b11);

    hbs_cmd_fifo #(.DEPTH(FIFO_DEPTH), .W(ENTRY_W)) fifo_i (
        .clk(clk), .rst(rst), .push(push), .din({cur_addr, wdata}),
        .pop(pop), .head(head), .full(fifo_full), .empty(fifo_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i]  <= '0;
                regs[i] <= '0;
            end
        end else begin
            if (wr_fire && !cur_attr.is_reg)
                mem[cur_addr] <= half_merge(mem[cur_addr], wdata, cur_attr.hen);
            if (pop)
                regs[head[ENTRY_W-1 -: ADDR_W]] <= head[DATA_W-1:0];
        end
    end

    always_comb begin
        if (cur_attr.is_reg) raw = (cur_attr.hen == 2'b11) ? regs[cur_addr] : '0;
        else                 raw = mem[cur_addr];
    end

    assign rdata_oe = rd_act;
    assign rdata    = rd_act ? half_zero(raw, cur_attr.hen) : '0;
endmodule

// File: rtl/hbs_checks.sv
module hbs_checks (
    input logic        clk,
    input logic        rst,
    input logic        last_n,
    input logic        rdy_n,
    input logic        stop_n,
    input logic        rdata_oe,
    input logic [31:0] rdata,
    input logic        fifo_full,
    input logic        fifo_empty,
    input logic        pop,
    input logic        is_reg
);
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
        (rdata_oe && !last_n) |=> (rdy_n && !rdata_oe)); // R4
    AST_OE_WITH_RDY: assert property (@(posedge clk) disable iff (rst)
        rdata_oe |-> !rdy_n); // R5
    AST_DRAIN_HALF: assert property (@(posedge clk) disable iff (rst)
        pop |=> !pop); // R7
    AST_STOP_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
        (!stop_n && !rdata_oe) |-> fifo_full); // R8
    AST_REG_READ_DRAINED: assert property (@(posedge clk) disable iff (rst)
        (rdata_oe && is_reg) |-> fifo_empty); // R9
    AST_REG_READ_STOP: assert property (@(posedge clk) disable iff (rst)
        (rdata_oe && is_reg) |-> !stop_n); // R10
    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (rst)
        !rdata_oe |-> (rdata == 32'h0)); // R13
endmodule

bind hbus_burst_slave hbs_checks chk_i (
    .clk(clk), .rst(rst), .last_n(last_n), .rdy_n(rdy_n), .stop_n(stop_n),
    .rdata_oe(rdata_oe), .rdata(rdata), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .pop(pop), .is_reg(cur_attr.is_reg)
);

// File: tb/hbus_burst_slave_tb_top.sv
module hbus_burst_slave_tb_top;
    localparam int AW = 4;
    localparam int NW = 1 << AW;

    typedef struct packed {
        logic        rnw;
        logic        is_reg;
        logic [3:0]  a;
        logic [1:0]  h;
        logic [4:0]  n;
        logic [31:0] seed;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 1'b0, 4'd2,  2'd3, 5'd4, 32'hA000_0001},
        '{1'b1, 1'b0, 4'd2,  2'd3, 5'd4, 32'h0},
        '{1'b0, 1'b0, 4'd14, 2'd3, 5'd4, 32'h1234_5678},
        '{1'b1, 1'b0, 4'd14, 2'd3, 5'd4, 32'h0},
        '{1'b0, 1'b0, 4'd3,  2'd1, 5'd1, 32'hFFFF_FFFF},
        '{1'b1, 1'b0, 4'd3,  2'd3, 5'd1, 32'h0},
        '{1'b1, 1'b0, 4'd2,  2'd2, 5'd2, 32'h0},
        '{1'b0, 1'b1, 4'd4,  2'd3, 5'd3, 32'h5A5A_0010},
        '{1'b1, 1'b1, 4'd4,  2'd3, 5'd3, 32'h0},
        '{1'b1, 1'b1, 4'd5,  2'd1, 5'd1, 32'h0},
        '{1'b0, 1'b1, 4'd4,  2'd2, 5'd1, 32'hDEAD_BEEF},
        '{1'b1, 1'b1, 4'd4,  2'd3, 5'd1, 32'h0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel_n = 1'b1, strb_n = 1'b1, rnw = 1'b0, reg_sel = 1'b0, last_n = 1'b1;
    logic [1:0]    hen = 2'b11;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic          rdy_n, stop_n, rdata_oe;
    logic [31:0]   rdata;

    logic [31:0] mem_m [NW];
    logic [31:0] reg_m [NW];
    int n_chk = 0, n_fail = 0;
    int stops_seen, last_wait;

    always #4 clk = ~clk;

    hbus_burst_slave #(.ADDR_W(AW), .FIFO_DEPTH(8)) dut_i (
        .clk(clk), .rst(rst), .sel_n(sel_n), .strb_n(strb_n), .rnw(rnw),
        .reg_sel(reg_sel), .last_n(last_n), .hen(hen), .addr(addr), .wdata(wdata),
        .rdy_n(rdy_n), .stop_n(stop_n), .rdata_oe(rdata_oe), .rdata(rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] msk(input logic [31:0] w, input logic [1:0] h);
        return {h[1] ? w[31:16] : 16'h0, h[0] ? w[15:0] : 16'h0};
    endfunction

    function automatic logic [31:0] wval(input logic [31:0] seed, input int k);
        return seed + 32'(k) * 32'h0101_0101;
    endfunction

    task automatic do_write(input logic isr, input logic [AW-1:0] a, input logic [1:0] h,
                            input int n, input logic [31:0] seed);
        logic [AW-1:0] wa;
        stops_seen = 0;
        @(negedge clk);
        sel_n = 0; strb_n = 0; rnw = 0; reg_sel = isr; addr = a; hen = h; last_n = 1;
        @(posedge clk);
        @(negedge clk);
        strb_n = 1; addr = ~a;
        chk("R3 ready in pre-data cycle", {31'b0, rdy_n}, 32'h0);
        @(posedge clk);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            wdata = wval(seed, k);
            last_n = (k == n - 1) ? 1'b0 : 1'b1;
            if (!isr) chk("R8 no stop on memory write", {31'b0, stop_n}, 32'h1);
            while (stop_n == 1'b0) begin
                stops_seen++;
                @(posedge clk);
                @(negedge clk);
            end
            wa = a + AW'(k);
            if (!isr) mem_m[wa] = (mem_m[wa] & ~msk(32'hFFFF_FFFF, h)) | msk(wval(seed, k), h);
            else if (h == 2'b11) reg_m[wa] = wval(seed, k);
            @(posedge clk);
        end
        @(negedge clk);
        chk("R4 ready released after last write", {31'b0, rdy_n}, 32'h1);
        last_n = 1; sel_n = 1;
        @(posedge clk);
    endtask

    task automatic do_read(input logic isr, input logic [AW-1:0] a, input logic [1:0] h,
                           input int n);
        logic [AW-1:0] ra;
        logic [31:0]   e;
        @(negedge clk);
        sel_n = 0; strb_n = 0; rnw = 1; reg_sel = isr; addr = a; hen = h;
        last_n = (n == 1) ? 1'b0 : 1'b1;
        @(posedge clk);
        @(negedge clk);
        strb_n = 1; addr = ~a;
        last_wait = 0;
        while (rdy_n == 1'b1 && last_wait < 200) begin
            last_wait++;
            @(posedge clk);
            @(negedge clk);
        end
        if (!isr) chk("R5 memory read latency", 32'(last_wait), 32'd1);
        for (int k = 0; k < n; k++) begin
            if (k > 0) @(negedge clk);
            ra = a + AW'(k);
            if (isr) e = (h == 2'b11) ? reg_m[ra] : 32'h0;
            else     e = msk(mem_m[ra], h);
            last_n = (k == n - 1) ? 1'b0 : 1'b1;
            chk(isr ? "R9 R12 register read data" : "R2 R11 memory read data", rdata, e);
            chk("R5 read drive enable", {30'b0, rdata_oe, rdy_n}, 32'h2);
            if (isr) chk("R10 stop with register read", {31'b0, stop_n}, 32'h0);
            @(posedge clk);
        end
        @(negedge clk);
        chk("R4 R13 bus released after last read", {30'b0, rdy_n, rdata_oe}, 32'h2);
        chk("R13 data zero when idle", rdata, 32'h0);
        last_n = 1; sel_n = 1;
        @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NW; i++) begin
            mem_m[i] = '0;
            reg_m[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 outputs in reset", {28'b0, rdy_n, stop_n, rdata_oe, 1'b0}, 32'hC);
        rst = 0;
        @(negedge clk);
        chk("R1 outputs after reset", {28'b0, rdy_n, stop_n, rdata_oe, 1'b0}, 32'hC);
        chk("R1 data after reset", rdata, 32'h0);

        // table of transfers
        for (int v = 0; v < NV; v++) begin
            if (TBL[v].rnw) do_read(TBL[v].is_reg, TBL[v].a, TBL[v].h, int'(TBL[v].n));
            else do_write(TBL[v].is_reg, TBL[v].a, TBL[v].h, int'(TBL[v].n), TBL[v].seed);
        end

        // R8: long register burst fills the queue
        do_write(1'b1, 4'd0, 2'b11, 24, 32'h7700_0000);
        chk("R8 stop seen on full queue", 32'(stops_seen > 0), 32'h1);
        do_read(1'b1, 4'd7, 2'b11, 2);

        // R7: half-rate drain leaves entries behind a short burst
        do_write(1'b1, 4'd8, 2'b11, 8, 32'h0C00_0040);
        do_read(1'b1, 4'd15, 2'b11, 1);
        chk("R7 read waited on slow drain", 32'(last_wait >= 4), 32'h1);

        // R6: strobe while still selected is ignored
        @(negedge clk);
        sel_n = 0; strb_n = 0; rnw = 0; reg_sel = 0; addr = 4'd5; hen = 2'b11; last_n = 1;
        @(posedge clk);
        @(negedge clk);
        strb_n = 1;
        @(posedge clk);
        @(negedge clk);
        wdata = 32'h0BAD_F00D; last_n = 0;
        mem_m[5] = 32'h0BAD_F00D;
        @(posedge clk);
        @(negedge clk);
        last_n = 1; strb_n = 0; wdata = 32'h1111_2222;
        @(posedge clk);
        @(negedge clk);
        strb_n = 1;
        chk("R6 no restart while selected", {31'b0, rdy_n}, 32'h1);
        @(posedge clk);
        @(negedge clk);
        chk("R6 still idle while selected", {31'b0, rdy_n}, 32'h1);
        sel_n = 1;
        @(posedge clk);
        do_read(1'b0, 4'd5, 2'b11, 1);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule